// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit CPU with a 16-bit address bus and a cartridge that holds a large external ROM and a banked external RAM. Writes that the CPU aims at the read-only window 0x0000-0x7FFF never reach the ROM. They are decoded by address as loads into four small control registers: a RAM enable, a 5-bit ROM bank, a shared 2-bit bank register, and a memory-model bit. From these registers and the CPU address the block forms a 21-bit ROM address and a 15-bit RAM address, drives the chip selects and the RAM write enable, and steers read data back to the CPU.

There are two memory models. After reset the large-ROM model is active: the 2-bit register supplies ROM bank bits 6:5, so up to 2 MB of ROM can be reached, and only RAM bank 0 is used. In the large-RAM model the same register picks one of four 8 KB RAM banks, and the ROM bank comes only from the 5-bit register, which limits the ROM to 512 KB. The lower 16 KB window always shows ROM bank 0. The upper 16 KB window never shows bank 0, because a bank value of zero is replaced by one.

Top module: `mbc_top`

## Requirements
- R1: After reset the ROM bank register holds 1, the 2-bit register holds 0, RAM is disabled and the large-ROM model is selected. A read of 0x4000 therefore gives rom_addr 0x04000.
- R2: A write anywhere in 0x6000-0x7FFF sets the model from data bit 0 (0 = large-ROM, 1 = large-RAM). Data bits 7:1 have no effect.
- R3: A write in 0x2000-0x3FFF loads data bits 4:0 as the ROM bank for 0x4000-0x7FFF. A value of 0 loads 1, and data bits 7:5 are ignored.
- R4: A CPU address in 0x0000-0x3FFF always gives rom_addr[20:14] = 0, whatever the bank registers hold.
- R5: A write in 0x4000-0x5FFF loads data bits 1:0 into the 2-bit register. In the large-ROM model it drives rom_addr[20:19] in the upper window, and ram_addr[14:13] is 0. In the large-RAM model it drives ram_addr[14:13], and rom_addr[20:19] is 0.
- R6: A write in 0x0000-0x1FFF enables RAM when data bits 3:0 equal 0xA, with bits 7:4 ignored. Any other value disables RAM.
- R7: While RAM is disabled, an access to 0xA000-0xBFFF asserts neither ram_cs nor ram_we, reads return 0xFF, and the RAM contents are left unchanged.
- R8: rom_addr = {bank, cpu_addr[13:0]} and ram_addr = {ram bank, cpu_addr[12:0]}. rom_cs is high on a read of 0x0000-0x7FFF. ram_cs is high on an enabled read or write of 0xA000-0xBFFF, and ram_we is high on the write case. cpu_rdata returns rom_rdata for 0x0000-0x7FFF, ram_rdata for enabled RAM, and 0xFF everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| rom_rdata | input | 8 | Data from the external ROM |
| ram_rdata | input | 8 | Data from the external RAM |
| rom_addr | output | 21 | Extended ROM address |
| ram_addr | output | 15 | Extended RAM address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
A register write takes effect at the clock edge on which it is taken, and every output is combinational from the registers and the CPU address. A corrupted bank, model or enable bit therefore shows up on rom_addr, ram_addr, the selects or cpu_rdata at the very next access that touches that window. A wrong RAM bank or a write that leaks past a disabled RAM is less direct: it shows up only when the bench later reads that RAM location back through the enabled window. For that reason the randomized stream mixes enable changes, model changes and RAM writes with read-backs.

// File: rtl/mbc_top.sv
module mbc_top #(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int BANK_W = LO_W + HI_W,
  localparam int ROM_AW = BANK_W + 14,
  localparam int RAM_AW = HI_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [7:0]        cpu_rdata
);

  logic [LO_W-1:0]   lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              mode_q;
  logic              ram_en_q;
  logic [BANK_W-1:0] bank;

  wire reg_wr  = cpu_wr & ~cpu_addr[15];
  wire ram_win = (cpu_addr[15:13] == 3'b101);
  wire [LO_W-1:0] lo_in = cpu_wdata[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= LO_W'(1);
      hi_q     <= '0;
      mode_q   <= 1'b0;
      ram_en_q <= 1'b0;
    end else if (reg_wr) begin
      case (cpu_addr[14:13])
        2'd0: ram_en_q <= (cpu_wdata[3:0] == 4'hA);
        2'd1: lo_q     <= (lo_in == '0) ? LO_W'(1) : lo_in;
        2'd2: hi_q     <= cpu_wdata[HI_W-1:0];
        default: mode_q <= cpu_wdata[0];
      endcase
    end
  end

  always_comb begin
    if (!cpu_addr[14])
      bank = '0;
    else if (mode_q)
      bank = {{HI_W{1'b0}}, lo_q};
    else
      bank = {hi_q, lo_q};
  end

  assign rom_addr  = {bank, cpu_addr[13:0]};
  assign ram_addr  = {(mode_q ? hi_q : HI_W'(0)), cpu_addr[12:0]};
  assign rom_cs    = cpu_rd & ~cpu_addr[15];
  assign ram_cs    = ram_en_q & ram_win & (cpu_rd | cpu_wr);
  assign ram_we    = ram_cs & cpu_wr;
  assign cpu_rdata = !cpu_addr[15]          ? rom_rdata :
                     (ram_win && ram_en_q)  ? ram_rdata : 8'hFF;

endmodule

module mbc_top_chk #(
  parameter int LO_W = 5,
  parameter int HI_W = 2,
  localparam int ROM_AW = LO_W + HI_W + 14,
  localparam int RAM_AW = HI_W + 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic [7:0]        cpu_wdata,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we,
  input logic [LO_W-1:0]   lo_q,
  input logic              mode_q,
  input logic              ram_en_q
);

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_wr && cpu_addr[15:13] == 3'b011) |-> mode_q == $past(cpu_wdata[0])); // R2

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_wr && cpu_addr[15:13] == 3'b001 && (cpu_wdata & 8'h1F) != 8'h00)
      |-> 8'(lo_q) == $past(cpu_wdata & 8'h1F)); // R3

  AST_NO_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> rom_addr[ROM_AW-3:14] != '0); // R3

  AST_LOW_WINDOW_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_AW-1:14] == '0); // R4

  AST_LARGE_ROM_RAMBANK: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> ram_addr[RAM_AW-1:13] == '0); // R5

  AST_LARGE_RAM_ROMTOP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> rom_addr[ROM_AW-1:ROM_AW-HI_W] == '0); // R5

  AST_RAM_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA) |-> !ram_cs); // R6

  AST_RAM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ram_en_q && cpu_addr[15:13] == 3'b101 && (cpu_rd || cpu_wr)); // R7

  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_cs && cpu_wr); // R8

  AST_ROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> cpu_rd && !cpu_addr[15]); // R8

endmodule

bind mbc_top mbc_top_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr), .ram_addr(ram_addr),
  .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we), .lo_q(lo_q),
  .mode_q(mode_q), .ram_en_q(ram_en_q)
);

// File: tb/tb_mbc_top.sv
module tb_mbc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  rom_rdata, ram_rdata, cpu_rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_cs, ram_cs, ram_we;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbc_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .ram_we(ram_we), .cpu_rdata(cpu_rdata)
  );

  logic [7:0] ram_mem [64];
  logic [7:0] m_ram   [64];
  logic [4:0] m_lo;
  logic [1:0] m_up;
  logic       m_mode, m_en;

  function automatic logic [7:0] rom_val(input logic [20:0] r);
    return r[7:0] ^ {r[20:14], r[8]};
  endfunction

  assign rom_rdata = rom_val(rom_addr);
  assign ram_rdata = ram_mem[{ram_addr[14:13], ram_addr[3:0]}];
  always @(posedge clk) if (ram_we) ram_mem[{ram_addr[14:13], ram_addr[3:0]}] <= cpu_wdata;

  function automatic logic [20:0] e_rom_addr(input logic [15:0] a);
    logic [6:0] b;
    if (!a[14]) b = '0;
    else if (m_mode) b = {2'b00, m_lo};
    else b = {m_up, m_lo};
    return {b, a[13:0]};
  endfunction

  function automatic logic [14:0] e_ram_addr(input logic [15:0] a);
    return {(m_mode ? m_up : 2'b00), a[12:0]};
  endfunction

  function automatic logic [7:0] e_rdata(input logic [15:0] a);
    logic [14:0] ra;
    ra = e_ram_addr(a);
    if (!a[15]) return rom_val(e_rom_addr(a));
    if (a[15:13] == 3'b101 && m_en) return m_ram[{ra[14:13], ra[3:0]}];
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_rd(input logic [15:0] a, input string tag);
    logic ramw;
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
    #1;
    ramw = (a[15:13] == 3'b101);
    chk({tag, " R8 rdata"}, 32'(cpu_rdata), 32'(e_rdata(a)));
    chk({tag, " R8 rom_cs"}, 32'(rom_cs), 32'(!a[15]));
    chk({tag, " R7 ram_cs"}, 32'(ram_cs), 32'(ramw && m_en));
    if (!a[15]) chk({tag, " R4 rom_addr"}, 32'(rom_addr), 32'(e_rom_addr(a)));
    if (ramw && m_en) chk({tag, " R5 ram_addr"}, 32'(ram_addr), 32'(e_ram_addr(a)));
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    logic ramw;
    logic [14:0] ra;
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    #1;
    ramw = (a[15:13] == 3'b101);
    chk({tag, " R7 ram_we"}, 32'(ram_we), 32'(ramw && m_en));
    chk({tag, " R8 rom_cs"}, 32'(rom_cs), 32'(0));
    if (!a[15]) begin
      case (a[14:13])
        2'd0: m_en = (d[3:0] == 4'hA);
        2'd1: m_lo = (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
        2'd2: m_up = d[1:0];
        default: m_mode = d[0];
      endcase
    end else if (ramw && m_en) begin
      ra = e_ram_addr(a);
      m_ram[{ra[14:13], ra[3:0]}] = d;
    end
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned sd;
    logic [15:0] a;
    logic [7:0]  d;
    int op;
    sd = $urandom(32'h0000_5EED);
    for (int i = 0; i < 64; i++) begin
      ram_mem[i] = 8'(i * 37 + 11);
      m_ram[i]   = 8'(i * 37 + 11);
    end
    m_lo = 5'd1; m_up = 2'd0; m_mode = 1'b0; m_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    do_rd(16'h4000, "R1 reset bank1");
    chk("R1 rom_addr after reset", 32'(rom_addr), 32'h0000_4000);
    do_rd(16'hA000, "R1 reset ram off");
    chk("R1 rdata ram disabled", 32'(cpu_rdata), 32'h0000_00FF);

    // R3 bank load and zero remap
    do_wr(16'h2000, 8'h00, "R3 wr0");
    do_rd(16'h4123, "R3 zero->1");
    chk("R3 zero maps to bank1", 32'(rom_addr[20:14]), 32'd1);
    do_wr(16'h3FFF, 8'hE0, "R3 wrE0");
    do_rd(16'h7FFF, "R3 upper bits ignored");
    chk("R3 E0 maps to bank1", 32'(rom_addr[20:14]), 32'd1);
    do_wr(16'h2000, 8'h1F, "R3 wr1F");
    do_rd(16'h5000, "R3 bank1F");
    chk("R3 bank 1F", 32'(rom_addr[20:14]), 32'h1F);
    do_wr(16'h2000, 8'h05, "R3 wr05");

    // R4 low window
    do_rd(16'h0000, "R4 low0");
    do_rd(16'h3FFF, "R4 low3FFF");
    chk("R4 low window bank0", 32'(rom_addr[20:14]), 32'd0);

    // R5 large-ROM upper bits
    do_wr(16'h4000, 8'hFE, "R5 up2");
    do_rd(16'h4000, "R5 largeROM");
    chk("R5 rom bank 45", 32'(rom_addr[20:14]), 32'h45);

    // R6 enable, write, read back in bank 0
    do_wr(16'h0000, 8'h1A, "R6 enable");
    do_wr(16'hA005, 8'h5C, "R6 ram wr");
    do_rd(16'hA005, "R6 ram rd");
    chk("R5 largeROM ram bank0", 32'(ram_addr[14:13]), 32'd0);

    // R2 model switch
    do_wr(16'h6000, 8'hFF, "R2 largeRAM");
    do_rd(16'h4000, "R2 largeRAM rom");
    chk("R5 largeRAM rom bank 05", 32'(rom_addr[20:14]), 32'h05);
    do_wr(16'hA005, 8'h77, "R2 bank2 wr");
    do_rd(16'hA005, "R2 bank2 rd");
    chk("R5 largeRAM ram bank2", 32'(ram_addr[14:13]), 32'd2);
    chk("R5 bank2 data", 32'(cpu_rdata), 32'h77);
    do_wr(16'h7ABC, 8'hFE, "R2 back largeROM");
    do_rd(16'hA005, "R2 bank0 again");
    chk("R2 bit0 only, bank0 data", 32'(cpu_rdata), 32'h5C);

    // R6/R7 disable protects contents
    do_wr(16'h1FFF, 8'h0B, "R6 disable");
    do_rd(16'hA005, "R7 disabled rd");
    chk("R7 disabled reads FF", 32'(cpu_rdata), 32'hFF);
    do_wr(16'hA005, 8'h99, "R7 disabled wr");
    do_wr(16'h0000, 8'h0A, "R6 reenable");
    do_rd(16'hA005, "R7 contents kept");
    chk("R7 contents kept", 32'(cpu_rdata), 32'h5C);

    // R8 outside windows
    do_rd(16'hC000, "R8 high area");
    chk("R8 high area FF", 32'(cpu_rdata), 32'hFF);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      op = $urandom_range(0, 9);
      a  = 16'($urandom);
      d  = 8'($urandom);
      if (op <= 3) begin
        if (a[15] && $urandom_range(0, 1) == 0) a[15:13] = 3'b101;
        do_rd(a, "rand rd");
      end else if (op <= 6) begin
        a[15] = 1'b0;
        if ($urandom_range(0, 2) == 0) d[3:0] = 4'hA;
        do_wr(a, d, "rand reg wr");
      end else begin
        a[15:13] = 3'b101;
        do_wr(a, d, "rand ram wr");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule